// File: doc/BRIEF.md
# Scatter-Gather DMA Channel Engine

This block is a single DMA channel that walks a chain of transfer descriptors kept in memory. A start pulse hands it the address of the first descriptor. For every descriptor the channel reads four words over its bus port, checks the chunk settings, and then copies the data. Each beat is a read at the source address followed by a write at the destination address. Beats are grouped into bursts, and every burst opens with a fresh address phase. A peripheral FIFO is reached as an address that does not advance. When a chunk asks for pacing, the channel waits for one peripheral request before each burst.

Every chunk carries its own beat width, burst length and address step mode for each side. A list ends at a zero next-pointer. In cyclic mode a zero next-pointer instead sends the channel back to the first descriptor, so a ring buffer is served until a stop arrives. The channel reports a residue byte count at one of three granularities, holds sticky done and error flags, and emits a one-cycle interrupt pulse on each reported event.

Top module: `sgdma_channel`

## Requirements
- R1: The width code in a descriptor selects the bytes per beat: 0 gives 1 byte, 1 gives 2, 2 gives 3 and 3 gives 4. Write data sits in the low bytes of `bus_wdata`, and `bus_be` has exactly that many low bits set.
- R2: A descriptor is four 32-bit little-endian words at the following offsets from its address:
  - +0: source address.
  - +4: destination address.
  - +8: control word, with size in bytes [15:0], width code [17:16], burst length minus one [21:18], source mode [23:22], destination mode [25:24], and paced [26].
  - +12: next-pointer.
  
  The channel fetches descriptors one after another by following the next-pointers. Read data on `bus_rdata` is valid the cycle after `bus_rd`.
- R3: A side whose mode is 1 advances its address by the beat width after every beat. Mode 2 steps the address down by the beat width. Mode 0 (and 3) holds the address fixed, as needed for a peripheral FIFO register.
- R4: A burst holds at most burst-length beats, and the final burst of a chunk may be shorter. `bus_first` marks both the read and the write of the first beat of each burst. Read and write are never active in the same cycle.
- R5: For a paced chunk, no beat of a burst starts until `periph_req` is sampled high. `periph_ack` is high in the cycle a request is taken, and each request authorises exactly one burst.
- R6: When a non-cyclic list reaches a zero next-pointer after its last chunk, the channel sets `done`, pulses `irq` for one cycle, sets the residue to 0 and returns to idle. With list granularity, that pulse is the only interrupt of the run.
- R7: A chunk whose size is zero or is not a whole multiple of its beat width sets `err` and pulses `irq`. The channel then halts without moving any data. A new start clears `err` and `done`.
- R8: With `cyclic` high at start, a zero next-pointer returns the channel to the first descriptor, and the transfer continues until it is stopped.
- R9: A `stop` pulse while busy takes effect at the next burst boundary. The channel goes idle with `done` low, and the residue shows the bytes of the current chunk that were not moved.
- R10: The residue granularity is taken at start. Code 0 (list) updates the residue only at completion or stop. Code 1 (chunk) also loads the chunk size when a chunk is accepted and writes 0 when it finishes. Code 2 (burst) additionally writes the remaining bytes and pulses `irq` after every burst.
- R11: After reset the channel is idle, with `busy`, `done`, `err`, `irq`, `bus_rd` and `bus_wr` low and the residue at 0. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a list walk (taken when idle) |
| head_addr | input | AW | Address of the first descriptor |
| cyclic | input | 1 | Wrap to the first descriptor at a zero next-pointer |
| resid_gran | input | 2 | Residue granularity: 0 list, 1 chunk, 2 burst |
| stop | input | 1 | Abort at the next burst boundary |
| periph_req | input | 1 | Peripheral request, one burst per request |
| periph_ack | output | 1 | Request accepted this cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | 32 | Write data, low-aligned |
| bus_be | output | 4 | Byte enables, low-aligned |
| bus_first | output | 1 | First beat of a burst (address phase) |
| bus_rdata | input | 32 | Read data, valid one cycle after `bus_rd` |
| busy | output | 1 | Channel active |
| done | output | 1 | List completed (sticky until next start) |
| err | output | 1 | Bad chunk size seen (sticky until next start) |
| irq | output | 1 | One-cycle event pulse |
| residue | output | 16 | Bytes left in the current chunk, updated per granularity |

## Verification
`busy` rises on the edge that takes `start`. A descriptor costs eight bus cycles plus one check cycle before the first burst can begin. Each beat takes two cycles: a read, then the write, which carries the data returned one cycle after the read. `periph_ack` is combinational in the waiting cycle. Residue, `irq` and the flags are registered, so they change one edge after the beat or decision that causes them, and a stop is registered and then acted on at the next waiting-state edge. The bench drives on falling edges and samples on falling edges only after polling `busy` low or after fixed waits that exceed these latencies, so each result is read once it has settled.

// File: rtl/sgdma_pkg.sv
// Package: shared types for the scatter-gather DMA channel.
// Assumes a 32-bit data bus and a 32-bit descriptor control word.
package sgdma_pkg;
    localparam int DATA_W     = 32;
    localparam int SIZE_W     = 16;
    localparam int BURST_W    = 4;
    localparam int BE_W       = DATA_W / 8;
    localparam int DESC_WORDS = 4;
    localparam int WIDX_W     = $clog2(DESC_WORDS);
    localparam int CTRL_PAD_W = DATA_W - SIZE_W - 2 - BURST_W - 2 - 2 - 1;

    // Per-side address step mode
    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_HOLD  = 2'd3
    } addr_mode_e;

    // Residue reporting granularity
    typedef enum logic [1:0] {
        RG_LIST  = 2'd0,
        RG_CHUNK = 2'd1,
        RG_BURST = 2'd2,
        RG_RSVD  = 2'd3
    } resid_gran_e;

    // Descriptor control word (third word)
    typedef struct packed {
        logic [CTRL_PAD_W-1:0] pad;
        logic                  paced;
        addr_mode_e            dst_mode;
        addr_mode_e            src_mode;
        logic [BURST_W-1:0]    burst_m1;
        logic [1:0]            wcode;
        logic [SIZE_W-1:0]     size;
    } chunk_ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_RD,
        ST_FETCH_CAP,
        ST_CHECK,
        ST_WAIT_REQ,
        ST_BEAT_RD,
        ST_BEAT_WR,
        ST_NEXT
    } ch_state_e;
endpackage

// File: rtl/sgdma_addr_step.sv
// Module: one side's address register. Loads a base address and then
// moves by the beat width after each beat according to the side mode.
// Assumes nbytes is 1..4 and that load and advance are never both high.
module sgdma_addr_step
    import sgdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  addr_mode_e    mode,
    input  logic          advance,
    input  logic [2:0]    nbytes,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] step_amt;
    assign step_amt = AW'(nbytes);

    // Purpose: hold, load or step the side address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (advance) begin
            case (mode)
                AM_INC:  addr <= addr + step_amt;
                AM_DEC:  addr <= addr - step_amt;
                default: addr <= addr;
            endcase
        end
    end
endmodule

// File: rtl/sgdma_chunk_check.sv
// Module: combinational decode of a chunk control word. It returns the
// beat width in bytes, the byte-enable shape, the burst length and
// whether the size is legal (nonzero and a whole number of beats).
module sgdma_chunk_check
    import sgdma_pkg::*;
(
    input  chunk_ctrl_t        ctrl,
    output logic [2:0]         nbytes,
    output logic [BE_W-1:0]    be_mask,
    output logic [BURST_W:0]   burst_len,
    output logic               size_ok
);
    logic multiple;

    // Purpose: width code to byte count and enable mask
    always_comb begin
        case (ctrl.wcode)
            2'd0:    begin nbytes = 3'd1; be_mask = 4'b0001; end
            2'd1:    begin nbytes = 3'd2; be_mask = 4'b0011; end
            2'd2:    begin nbytes = 3'd3; be_mask = 4'b0111; end
            default: begin nbytes = 3'd4; be_mask = 4'b1111; end
        endcase
    end

    // Purpose: size must be a whole multiple of the beat width
    always_comb begin
        case (ctrl.wcode)
            2'd0:    multiple = 1'b1;
            2'd1:    multiple = (ctrl.size[0] == 1'b0);
            2'd2:    multiple = ((ctrl.size % SIZE_W'(3)) == '0);
            default: multiple = (ctrl.size[1:0] == 2'b00);
        endcase
    end

    assign size_ok   = multiple && (ctrl.size != '0);
    assign burst_len = {1'b0, ctrl.burst_m1} + (BURST_W+1)'(1);
endmodule

// File: rtl/sgdma_channel.sv
// Module: top of the scatter-gather DMA channel. It fetches linked
// descriptors, checks each chunk, and runs request-paced bursts of
// read-then-write beats. It also tracks the residue, the done and
// error flags and the interrupt pulse.
// Assumes AW <= 32 and a bus whose read data arrives one cycle after
// the read strobe, with no wait states.
module sgdma_channel
    import sgdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     head_addr,
    input  logic              cyclic,
    input  logic [1:0]        resid_gran,
    input  logic              stop,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [AW-1:0]     bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [BE_W-1:0]   bus_be,
    output logic              bus_first,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              irq,
    output logic [SIZE_W-1:0] residue
);
    localparam int NSIDE = 2;

    ch_state_e          state;
    logic [AW-1:0]      head_q, ptr_q, next_q, src_base_q, dst_base_q;
    logic [WIDX_W-1:0]  widx_q;
    chunk_ctrl_t        ctrl_q;
    logic [SIZE_W-1:0]  rem_q, resid_q;
    logic [BURST_W:0]   beat_q;
    resid_gran_e        gran_q;
    logic               cyclic_q, stop_pend_q, done_q, err_q, irq_q;

    logic [2:0]         nbytes;
    logic [BE_W-1:0]    be_mask;
    logic [BURST_W:0]   burst_len;
    logic               size_ok;
    logic [SIZE_W-1:0]  rem_after;
    logic               last_beat, burst_end, side_load, side_adv;
    logic [DATA_W-1:0]  lane_mask;

    logic [AW-1:0]      side_base [NSIDE];
    addr_mode_e         side_mode [NSIDE];
    logic [AW-1:0]      side_addr [NSIDE];

    sgdma_chunk_check u_check (
        .ctrl      (ctrl_q),
        .nbytes    (nbytes),
        .be_mask   (be_mask),
        .burst_len (burst_len),
        .size_ok   (size_ok)
    );

    assign side_base[0] = src_base_q;
    assign side_base[1] = dst_base_q;
    assign side_mode[0] = ctrl_q.src_mode;
    assign side_mode[1] = ctrl_q.dst_mode;
    assign side_load    = (state == ST_CHECK) && size_ok;
    assign side_adv     = (state == ST_BEAT_WR);

    generate
        for (genvar s = 0; s < NSIDE; s++) begin : g_side
            sgdma_addr_step #(.AW(AW)) u_step (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (side_load),
                .base    (side_base[s]),
                .mode    (side_mode[s]),
                .advance (side_adv),
                .nbytes  (nbytes),
                .addr    (side_addr[s])
            );
        end
        for (genvar b = 0; b < BE_W; b++) begin : g_lane
            assign lane_mask[8*b +: 8] = {8{be_mask[b]}};
        end
    endgenerate

    assign rem_after = rem_q - SIZE_W'(nbytes);
    assign last_beat = (rem_q == SIZE_W'(nbytes));
    assign burst_end = ((beat_q + (BURST_W+1)'(1)) == burst_len);

    // Purpose: bus strobes, address, data and burst marker from state
    always_comb begin
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_be    = '0;
        case (state)
            ST_FETCH_RD: begin
                bus_rd   = 1'b1;
                bus_addr = ptr_q + AW'({widx_q, 2'b00});
                bus_be   = '1;
            end
            ST_BEAT_RD: begin
                bus_rd   = 1'b1;
                bus_addr = side_addr[0];
                bus_be   = be_mask;
            end
            ST_BEAT_WR: begin
                bus_wr    = 1'b1;
                bus_addr  = side_addr[1];
                bus_be    = be_mask;
                bus_wdata = bus_rdata & lane_mask;
            end
            default: ;
        endcase
    end

    assign bus_first  = ((state == ST_BEAT_RD) || (state == ST_BEAT_WR)) && (beat_q == '0);
    assign periph_ack = (state == ST_WAIT_REQ) && ctrl_q.paced && periph_req && !stop_pend_q;
    assign busy       = (state != ST_IDLE);
    assign done       = done_q;
    assign err        = err_q;
    assign irq        = irq_q;
    assign residue    = resid_q;

    // Purpose: remember a stop request until the next burst boundary
    always_ff @(posedge clk) begin
        if (!rst_n)                stop_pend_q <= 1'b0;
        else if (state == ST_IDLE) stop_pend_q <= 1'b0;
        else if (stop)             stop_pend_q <= 1'b1;
    end

    // Purpose: channel sequencer covering fetch, check, bursts and list walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            head_q     <= '0;
            ptr_q      <= '0;
            next_q     <= '0;
            src_base_q <= '0;
            dst_base_q <= '0;
            widx_q     <= '0;
            ctrl_q     <= '0;
            rem_q      <= '0;
            resid_q    <= '0;
            beat_q     <= '0;
            gran_q     <= RG_LIST;
            cyclic_q   <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        head_q   <= head_addr;
                        ptr_q    <= head_addr;
                        widx_q   <= '0;
                        cyclic_q <= cyclic;
                        gran_q   <= resid_gran_e'(resid_gran);
                        done_q   <= 1'b0;
                        err_q    <= 1'b0;
                        state    <= ST_FETCH_RD;
                    end
                end
                ST_FETCH_RD: state <= ST_FETCH_CAP;
                ST_FETCH_CAP: begin
                    case (widx_q)
                        2'd0:    src_base_q <= bus_rdata[AW-1:0];
                        2'd1:    dst_base_q <= bus_rdata[AW-1:0];
                        2'd2:    ctrl_q     <= chunk_ctrl_t'(bus_rdata);
                        default: next_q     <= bus_rdata[AW-1:0];
                    endcase
                    widx_q <= widx_q + 1'b1;
                    state  <= (widx_q == WIDX_W'(DESC_WORDS-1)) ? ST_CHECK : ST_FETCH_RD;
                end
                ST_CHECK: begin
                    if (!size_ok) begin
                        err_q <= 1'b1;
                        irq_q <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        rem_q  <= ctrl_q.size;
                        beat_q <= '0;
                        if (gran_q != RG_LIST) resid_q <= ctrl_q.size;
                        state  <= ST_WAIT_REQ;
                    end
                end
                ST_WAIT_REQ: begin
                    if (stop_pend_q) begin
                        resid_q <= rem_q;
                        state   <= ST_IDLE;
                    end else if (!ctrl_q.paced || periph_req) begin
                        beat_q <= '0;
                        state  <= ST_BEAT_RD;
                    end
                end
                ST_BEAT_RD: state <= ST_BEAT_WR;
                ST_BEAT_WR: begin
                    rem_q  <= rem_after;
                    beat_q <= beat_q + 1'b1;
                    if (last_beat) begin
                        if (gran_q != RG_LIST) begin
                            resid_q <= '0;
                            irq_q   <= 1'b1;
                        end
                        state <= ST_NEXT;
                    end else if (burst_end) begin
                        if (gran_q == RG_BURST) begin
                            resid_q <= rem_after;
                            irq_q   <= 1'b1;
                        end
                        beat_q <= '0;
                        state  <= ST_WAIT_REQ;
                    end else begin
                        state <= ST_BEAT_RD;
                    end
                end
                ST_NEXT: begin
                    if (stop_pend_q) begin
                        resid_q <= '0;
                        state   <= ST_IDLE;
                    end else if ((next_q == '0) && !cyclic_q) begin
                        done_q  <= 1'b1;
                        irq_q   <= 1'b1;
                        resid_q <= '0;
                        state   <= ST_IDLE;
                    end else begin
                        ptr_q  <= (next_q == '0) ? head_q : next_q;
                        widx_q <= '0;
                        state  <= ST_FETCH_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgdma_channel_chk.sv
// Module: protocol checker for sgdma_channel, attached by bind.
// Observes ports only and assumes the synchronous active-low reset.
module sgdma_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       bus_first,
    input logic [3:0] bus_be,
    input logic       periph_req,
    input logic       periph_ack
);
    // R4: read and write strobes are exclusive
    p_rdwr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R4: a first-beat write follows the first-beat read of the same burst
    p_first_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_first) |-> ($past(bus_rd) && $past(bus_first)));

    // R1: write enables are a contiguous low-aligned run
    p_be_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_be == 4'b0001 || bus_be == 4'b0011 ||
                    bus_be == 4'b0111 || bus_be == 4'b1111));

    // R5: an accepted request needs the request line high
    p_ack_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> periph_req);

    // R6: a finished channel is idle and quiet on the bus
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !bus_rd && !bus_wr));

    // R7: an error halts the channel
    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    // R11: no bus activity while idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd && !bus_wr));
endmodule

bind sgdma_channel sgdma_channel_chk u_sgdma_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_first  (bus_first),
    .bus_be     (bus_be),
    .periph_req (periph_req),
    .periph_ack (periph_ack)
);

// File: tb/sgdma_channel_bench.sv
`timescale 1ns/1ps
// Bench: byte-accurate memory model with a fixed-address FIFO sink,
// a table of copy vectors, then directed tests for lists, pacing,
// errors, cyclic looping and stop.
module sgdma_channel_bench;
    localparam int AW = 32;
    localparam logic [9:0] FIFO_A = 10'h3F0;

    // Vector fields: size[25:10] wcode[9:8] burst-1[7:4] srcmode[3:2] dstmode[1:0]
    localparam logic [25:0] VEC [7] = '{
        {16'd16, 2'd3, 4'd3,  2'd1, 2'd1},
        {16'd12, 2'd1, 4'd3,  2'd1, 2'd1},
        {16'd15, 2'd2, 4'd1,  2'd1, 2'd1},
        {16'd7,  2'd0, 4'd2,  2'd1, 2'd2},
        {16'd24, 2'd3, 4'd0,  2'd2, 2'd2},
        {16'd20, 2'd1, 4'd15, 2'd1, 2'd1},
        {16'd9,  2'd2, 4'd3,  2'd2, 2'd1}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, start, cyclic, stop, periph_req;
    logic [1:0]    resid_gran;
    logic [AW-1:0] head_addr;
    logic          periph_ack, bus_rd, bus_wr, bus_first, busy, done, err, irq;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic [3:0]    bus_be;
    logic [15:0]   residue;

    sgdma_channel #(.AW(AW)) u_sgdma_channel (
        .clk(clk), .rst_n(rst_n), .start(start), .head_addr(head_addr),
        .cyclic(cyclic), .resid_gran(resid_gran), .stop(stop),
        .periph_req(periph_req), .periph_ack(periph_ack),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_first(bus_first),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .err(err),
        .irq(irq), .residue(residue)
    );

    logic [7:0] mem [1024];
    logic [7:0] fifo_log [64];
    int fifo_n = 0;
    int n_bursts = 0, n_irq = 0, n_wr = 0, n_mem_wr = 0, n_ack = 0;
    int vecs = 0, fails = 0;

    function automatic logic [7:0] pat(int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    // Memory model: registered read, byte-enabled write, FIFO sink
    always @(posedge clk) begin
        if (bus_rd)
            bus_rdata <= {mem[10'(bus_addr[9:0]+3)], mem[10'(bus_addr[9:0]+2)],
                          mem[10'(bus_addr[9:0]+1)], mem[bus_addr[9:0]]};
        if (bus_wr) begin
            if (bus_addr[9:0] == FIFO_A) begin
                fifo_log[fifo_n[5:0]] <= bus_wdata[7:0];
                fifo_n <= fifo_n + 1;
            end else begin
                for (int j = 0; j < 4; j++)
                    if (bus_be[j]) mem[10'(bus_addr[9:0]+j)] <= bus_wdata[8*j +: 8];
            end
        end
    end

    // Monitor: event counters sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_wr && bus_first) n_bursts <= n_bursts + 1;
            if (irq) n_irq <= n_irq + 1;
            if (bus_wr) n_wr <= n_wr + 1;
            if (bus_wr && bus_addr[9:0] != FIFO_A) n_mem_wr <= n_mem_wr + 1;
            if (periph_ack) n_ack <= n_ack + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int j = 0; j < 4; j++) mem[10'(a+j)] = v[8*j +: 8];
    endtask

    task automatic put_desc(input int a, input int s, input int d, input logic [31:0] c, input int nx);
        put32(a, 32'(s)); put32(a+4, 32'(d)); put32(a+8, c); put32(a+12, 32'(nx));
    endtask

    function automatic logic [31:0] mk_ctrl(int size, int wc, int bm1, int sm, int dm, bit paced);
        return {5'd0, paced, 2'(dm), 2'(sm), 4'(bm1), 2'(wc), 16'(size)};
    endfunction

    task automatic fill_mem();
        for (int a = 16'h100; a < 16'h200; a++) mem[a] = pat(a);
        for (int a = 16'h200; a < 16'h300; a++) mem[a] = 8'h00;
    endtask

    function automatic int copy_errs(int s, int d, int sm, int dm, int nb, int beats);
        int e = 0;
        for (int i = 0; i < beats; i++) begin
            int sa = s + ((sm == 1) ? i*nb : (sm == 2) ? -i*nb : 0);
            int da = d + ((dm == 1) ? i*nb : (dm == 2) ? -i*nb : 0);
            for (int j = 0; j < nb; j++)
                if (mem[10'(da+j)] !== pat(sa+j)) e++;
        end
        return e;
    endfunction

    task automatic kick(input int head, input bit cyc, input int gran);
        @(negedge clk);
        head_addr = AW'(head); cyclic = cyc; resid_gran = 2'(gran); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        check(!busy, tag, int'(busy), 0);
    endtask

    task automatic pulse_req();
        @(negedge clk); periph_req = 1'b1;
        @(negedge clk); periph_req = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        int b0, i0, w0, m0, f0, a0;
        rst_n = 1'b0; start = 1'b0; cyclic = 1'b0; stop = 1'b0;
        periph_req = 1'b0; resid_gran = 2'd0; head_addr = '0;
        for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!busy && !bus_rd && !bus_wr, "R11 idle after reset", int'(busy), 0);
        check(!done && !err, "R11 flags clear", int'(done | err), 0);
        check(!irq, "R11 irq low", int'(irq), 0);
        check(residue == 0, "R11 residue zero", int'(residue), 0);

        // Vector table: one chunk copies, list granularity
        for (int v = 0; v < 7; v++) begin
            int size = int'(VEC[v][25:10]);
            int wc   = int'(VEC[v][9:8]);
            int bm1  = int'(VEC[v][7:4]);
            int sm   = int'(VEC[v][3:2]);
            int dm   = int'(VEC[v][1:0]);
            int nb   = wc + 1;
            int beats = size / nb;
            int exp_b = (beats + bm1) / (bm1 + 1);
            int s = (sm == 2) ? 16'h1C0 : 16'h100;
            int d = (dm == 2) ? 16'h2C0 : 16'h200;
            fill_mem();
            put_desc(0, s, d, mk_ctrl(size, wc, bm1, sm, dm, 1'b0), 0);
            b0 = n_bursts; i0 = n_irq;
            kick(0, 1'b0, 0);
            wait_idle("R6 vector run ends");
            @(negedge clk);
            check(copy_errs(s, d, sm, dm, nb, beats) == 0, "R1/R3 copied bytes",
                  copy_errs(s, d, sm, dm, nb, beats), 0);
            check(n_bursts - b0 == exp_b, "R4 burst count", n_bursts - b0, exp_b);
            check(done && !err, "R6 done set", int'(done), 1);
            check(n_irq - i0 == 1, "R6 single irq at list granularity", n_irq - i0, 1);
            check(residue == 0, "R10 residue zero at end", int'(residue), 0);
        end

        // R7: size not a multiple of width halts with error, no writes
        put_desc(16'h60, 16'h100, 16'h200, mk_ctrl(5, 1, 3, 1, 1, 1'b0), 0);
        i0 = n_irq; w0 = n_wr;
        kick(16'h60, 1'b0, 0);
        wait_idle("R7 error run ends");
        @(negedge clk);
        check(err && !done, "R7 err flag", int'(err), 1);
        check(n_wr == w0, "R7 no data moved", n_wr - w0, 0);
        check(n_irq - i0 == 1, "R7 irq on error", n_irq - i0, 1);

        // R2: two linked descriptors; a new start also clears err (R7)
        fill_mem();
        put_desc(16'h80, 16'h100, 16'h200, mk_ctrl(8, 3, 3, 1, 1, 1'b0), 16'hA0);
        put_desc(16'hA0, 16'h140, 16'h240, mk_ctrl(6, 1, 0, 1, 1, 1'b0), 0);
        b0 = n_bursts;
        kick(16'h80, 1'b0, 0);
        check(!err, "R7 start clears err", int'(err), 0);
        wait_idle("R2 list run ends");
        @(negedge clk);
        check(copy_errs(16'h100, 16'h200, 1, 1, 4, 2) == 0, "R2 first chunk",
              copy_errs(16'h100, 16'h200, 1, 1, 4, 2), 0);
        check(copy_errs(16'h140, 16'h240, 1, 1, 2, 3) == 0, "R2 second chunk",
              copy_errs(16'h140, 16'h240, 1, 1, 2, 3), 0);
        check(n_bursts - b0 == 4, "R4 bursts across list", n_bursts - b0, 4);
        check(done, "R6 done after list", int'(done), 1);

        // R5: paced transfer into the fixed FIFO address, burst granularity
        fill_mem();
        put_desc(16'hC0, 16'h100, FIFO_A, mk_ctrl(16, 3, 1, 1, 0, 1'b1), 0);
        f0 = fifo_n; m0 = n_mem_wr; a0 = n_ack;
        kick(16'hC0, 1'b0, 2);
        repeat (40) @(negedge clk);
        check(fifo_n == f0, "R5 no beats without request", fifo_n - f0, 0);
        check(busy, "R5 waiting for request", int'(busy), 1);
        check(residue == 16, "R10 chunk size loaded", int'(residue), 16);
        kick(16'h00, 1'b0, 0);  // R11: start while busy is ignored
        pulse_req();
        repeat (20) @(negedge clk);
        check(fifo_n - f0 == 2, "R5 one burst per request", fifo_n - f0, 2);
        check(residue == 8, "R10 burst residue", int'(residue), 8);
        check(n_ack - a0 == 1, "R5 single ack", n_ack - a0, 1);
        pulse_req();
        wait_idle("R5 paced run ends");
        @(negedge clk);
        check(fifo_n - f0 == 4, "R5 all beats moved", fifo_n - f0, 4);
        check(n_mem_wr == m0, "R3 fixed destination address", n_mem_wr - m0, 0);
        check(fifo_log[6'(f0+3)] == pat(16'h10C), "R3 source stepped",
              int'(fifo_log[6'(f0+3)]), int'(pat(16'h10C)));
        check(done && residue == 0, "R6 paced done", int'(residue), 0);

        // R8/R9: cyclic ring into the FIFO, then stop mid-chunk
        put_desc(16'h40, 16'h100, FIFO_A, mk_ctrl(4, 0, 1, 1, 0, 1'b1), 0);
        f0 = fifo_n;
        kick(16'h40, 1'b1, 1);
        for (int r = 0; r < 5; r++) begin
            repeat (20) @(negedge clk);
            pulse_req();
        end
        repeat (20) @(negedge clk);
        check(busy, "R8 still running after wrap", int'(busy), 1);
        check(fifo_n - f0 == 10, "R8 bytes moved over wraps", fifo_n - f0, 10);
        for (int k = 0; k < 10; k++)
            check(fifo_log[6'(f0+k)] == pat(16'h100 + (k % 4)), "R8 ring order",
                  int'(fifo_log[6'(f0+k)]), int'(pat(16'h100 + (k % 4))));
        check(residue == 4, "R10 chunk residue holds between bursts", int'(residue), 4);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy, "R9 stopped", int'(busy), 0);
        check(residue == 2, "R9 residue shows unmoved bytes", int'(residue), 2);
        check(!done, "R9 done stays low", int'(done), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule